// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a memory burst. A one-cycle start pulse captures a 9-bit starting column together with a burst length code, an ordering bit, a read/write flag and a write-single-beat mode bit. From the next cycle on, the block presents one column per beat. The column moves to the next beat on each cycle in which the advance strobe is high.

The burst always stays inside the naturally aligned block of columns that holds the starting column. The beats are visited either in sequential order or in interleaved (XOR) order. A full-page burst walks the whole 512-column page, wraps around, and goes on until it is told to stop. Row, bank, command timing and the data path belong to the neighbouring logic.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and after it is released, `valid_o` and `last_o` are low until the first start pulse.
- R2: In the cycle after `start_i` is high, `valid_o` is 1 and `col_o` equals the captured `start_col_i` (beat 0). A start pulse during an active burst drops the old burst and begins the new one in that same cycle.
- R3: `len_code_i` selects the length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, 3'b111 gives full page, and 3'b100 to 3'b110 give 1 beat. `last_o` is high only on the final beat. An advance on the final beat makes `valid_o` low in the next cycle.
- R4: For a burst of length L, the column bits at position log2(L) and above never change during the burst. The low bits wrap inside the aligned block.
- R5: With `ilv_i`=0, the low log2(L) bits of beat i are (start + i) mod L.
- R6: With `ilv_i`=1, the low log2(L) bits of beat i are start XOR i.
- R7: A full-page burst gives column (start + i) mod 512, always in sequential order whatever `ilv_i` is. It never raises `last_o`.
- R8: A 1-beat burst ignores `ilv_i` and presents exactly the start column, with `last_o` high.
- R9: When `wr_i`=1 and `wr_single_i`=1, the burst is 1 beat long whatever `len_code_i` is. Reads, and writes with `wr_single_i`=0, use the programmed length.
- R10: With no active burst, `adv_i` has no effect. During a burst with `adv_i` low, the column and `valid_o` hold.
- R11: `term_i` high during an active burst (without a start pulse) makes `valid_o` low in the next cycle, for any length.
- R12: `start_i` takes priority over `adv_i` and `term_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, captures the burst parameters |
| start_col_i | input | 9 | Starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| wr_i | input | 1 | 1 = write burst, 0 = read burst |
| wr_single_i | input | 1 | 1 = writes are single beat |
| adv_i | input | 1 | Move to the next beat |
| term_i | input | 1 | End the active burst |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | The current beat is the final one |

## Verification
The assertions assume that the inputs are defined in every cycle after reset, and that no start pulse comes before the internal reset synchronizer has released. The bench holds the start strobe low for several cycles after reset and drives every input from time zero. The assertions also take the captured length mask as fixed until the next start. The stimulus therefore changes the length and type inputs freely between pulses, to show that only the captured values matter.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;
  localparam int unsigned COL_W = 9;
  localparam int unsigned LEN_W = 3;

  typedef enum logic [LEN_W-1:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_PAGE  = 3'b111
  } len_code_e;

  typedef struct packed {
    logic [COL_W-1:0] mask;
    logic             page;
    logic             ilv;
  } burst_cfg_t;
endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned CW = COL_W
) (
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             ilv_i,
  input  logic             wr_i,
  input  logic             wr_single_i,
  output logic [CW-1:0]    mask_o,
  output logic             page_o,
  output logic             ilv_o
);
  logic force_one;
  logic [CW-1:0] mask_raw;
  logic page_raw;

  assign force_one = wr_i & wr_single_i;

  always_comb begin
    mask_raw = '0;
    page_raw = 1'b0;
    case (len_code_i)
      LEN_TWO:   mask_raw = CW'(1);
      LEN_FOUR:  mask_raw = CW'(3);
      LEN_EIGHT: mask_raw = CW'(7);
      LEN_PAGE: begin
        mask_raw = '1;
        page_raw = 1'b1;
      end
      default:   mask_raw = '0;
    endcase
  end

  assign mask_o = force_one ? '0 : mask_raw;
  assign page_o = page_raw & ~force_one;
  // page bursts are sequential only; length one has no order
  assign ilv_o  = ilv_i & ~page_o & (mask_o != '0);
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned CW = COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] start_col_i,
  input  logic [CW-1:0] mask_i,
  input  logic          page_i,
  input  logic          ilv_i,
  input  logic          adv_i,
  input  logic          term_i,
  output logic          act_o,
  output logic          last_o,
  output logic [CW-1:0] idx_o,
  output logic [CW-1:0] scol_o,
  output logic [CW-1:0] mask_o,
  output logic          ilv_o
);
  logic          act_q, act_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          idx_en;
  logic          cfg_en;
  logic [CW-1:0] scol_q, mask_q;
  logic          page_q, ilv_q;
  logic          at_end;

  assign at_end = ~page_q & (idx_q == mask_q);
  assign cfg_en = start_i;

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (start_i) begin
      act_d  = 1'b1;
      idx_d  = '0;
      idx_en = 1'b1;
    end else if (act_q) begin
      if (term_i) begin
        act_d = 1'b0;
      end else if (adv_i) begin
        if (at_end) begin
          act_d = 1'b0;
        end else begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scol_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (cfg_en) begin
      scol_q <= start_col_i;
      mask_q <= mask_i;
      page_q <= page_i;
      ilv_q  <= ilv_i;
    end
  end

  assign act_o  = act_q;
  assign last_o = act_q & at_end;
  assign idx_o  = idx_q;
  assign scol_o = scol_q;
  assign mask_o = mask_q;
  assign ilv_o  = ilv_q;

  assert_term_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o && term_i && !start_i) |=> !act_o);
  assert_last_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && adv_i && !start_i) |=> !act_o);
  assert_idle_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_o && !start_i) |=> !act_o);
  assert_page_no_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && page_i) |=> !last_o);
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned CW = COL_W
) (
  input  logic [CW-1:0] scol_i,
  input  logic [CW-1:0] idx_i,
  input  logic [CW-1:0] mask_i,
  input  logic          ilv_i,
  output logic [CW-1:0] col_o
);
  logic [CW-1:0] seq_off, ilv_off, off;

  assign seq_off = scol_i + idx_i;
  assign ilv_off = scol_i ^ idx_i;
  assign off     = ilv_i ? ilv_off : seq_off;

  for (genvar b = 0; b < CW; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? off[b] : scol_i[b];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             ilv_i,
  input  logic             wr_i,
  input  logic             wr_single_i,
  input  logic             adv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic       rst_sync_n;
  burst_cfg_t cfg;
  logic [COL_W-1:0] idx, scol, mask_q;
  logic       ilv_q;

  bcs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bcs_len_decode #(.CW(COL_W)) u_dec (
    .len_code_i(len_code_i), .ilv_i(ilv_i), .wr_i(wr_i),
    .wr_single_i(wr_single_i),
    .mask_o(cfg.mask), .page_o(cfg.page), .ilv_o(cfg.ilv)
  );

  bcs_beat_ctrl #(.CW(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i),
    .start_col_i(start_col_i), .mask_i(cfg.mask), .page_i(cfg.page),
    .ilv_i(cfg.ilv), .adv_i(adv_i), .term_i(term_i),
    .act_o(valid_o), .last_o(last_o), .idx_o(idx), .scol_o(scol),
    .mask_o(mask_q), .ilv_o(ilv_q)
  );

  bcs_col_gen #(.CW(COL_W)) u_col (
    .scol_i(scol), .idx_i(idx), .mask_i(mask_q), .ilv_i(ilv_q),
    .col_o(col_o)
  );

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));
  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && wr_i && wr_single_i) |=> last_o);
  assert_block_kept_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_o && !start_i) |=> (!valid_o || ((col_o ^ $past(col_o)) & ~mask_q) == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_o && !adv_i && !term_i && !start_i) |=> (valid_o && $stable(col_o)));
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0, wr_i = 1'b0, wr_single_i = 1'b0;
  logic       adv_i = 1'b0, term_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_act = 0;
  int m_idx = 0, m_len = 1, m_scol = 0;
  bit m_page = 0, m_ilv = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .wr_i(wr_i),
    .wr_single_i(wr_single_i), .adv_i(adv_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int code_len(input logic [2:0] c);
    case (c)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int base, off;
    if (m_page) return (m_scol + m_idx) % 512;
    base = (m_scol / m_len) * m_len;
    off  = m_scol % m_len;
    if (m_ilv && m_len > 1) return base + (off ^ (m_idx % m_len));
    return base + ((off + m_idx) % m_len);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_act = 0;
    else if (start_i) begin
      m_act  = 1;
      m_idx  = 0;
      m_scol = int'(start_col_i);
      m_len  = (wr_i && wr_single_i) ? 1 : code_len(len_code_i);
      m_page = (m_len == 512);
      m_ilv  = ilv_i;
    end else if (m_act) begin
      if (term_i) m_act = 0;
      else if (adv_i) begin
        if (!m_page && m_idx == m_len - 1) m_act = 0;
        else m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit e_last;
      e_last = m_act && !m_page && (m_idx == m_len - 1);
      checks++;
      if (valid_o !== m_act) begin
        errors++;
        $display("FAIL %s valid_o got %0b expected %0b", cur_req, valid_o, m_act);
      end
      checks++;
      if (last_o !== e_last) begin
        errors++;
        $display("FAIL %s last_o got %0b expected %0b", cur_req, last_o, e_last);
      end
      if (m_act) begin
        checks++;
        if (int'(col_o) != exp_col()) begin
          errors++;
          $display("FAIL %s col_o got %0d expected %0d", cur_req, col_o, exp_col());
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    start_i = 0; adv_i = 0; term_i = 0;
  endtask

  task automatic kick(input int col, input logic [2:0] code, input bit ilv,
                      input bit wr, input bit wrs);
    @(negedge clk);
    start_i = 1; start_col_i = 9'(col); len_code_i = code; ilv_i = ilv;
    wr_i = wr; wr_single_i = wrs; adv_i = 0; term_i = 0;
    @(negedge clk);
    start_i = 0;
    // scramble config after capture: only captured values may matter
    len_code_i = 3'b011; ilv_i = ~ilv; wr_i = ~wr;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      adv_i = 1;
      @(negedge clk);
    end
    adv_i = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);

    cur_req = "R5"; kick(9'h0A6, 3'b010, 0, 0, 0); run(5);
    cur_req = "R6"; kick(9'h1F5, 3'b011, 1, 0, 0); run(9);
    cur_req = "R3"; kick(9'h033, 3'b001, 0, 0, 0); run(3);
    cur_req = "R4"; kick(9'h0FE, 3'b011, 0, 0, 0); run(9);
    cur_req = "R8"; kick(9'h155, 3'b000, 1, 0, 0); run(2);
    cur_req = "R3"; kick(9'h07B, 3'b101, 0, 0, 0); run(2);
    cur_req = "R9"; kick(9'h0C6, 3'b011, 0, 1, 1); run(2);
    cur_req = "R9"; kick(9'h0C6, 3'b010, 1, 1, 0); run(5);
    cur_req = "R9"; kick(9'h0C6, 3'b011, 1, 0, 1); run(9);
    cur_req = "R7"; kick(510, 3'b111, 1, 0, 0); run(600);
    repeat (3) idle();
    cur_req = "R11"; term_i = 1; @(negedge clk); term_i = 0; idle();
    cur_req = "R11"; kick(9'h020, 3'b011, 0, 0, 0); run(3);
    term_i = 1; @(negedge clk); term_i = 0; idle(); idle();
    cur_req = "R10"; adv_i = 1; repeat (4) @(negedge clk); adv_i = 0;
    kick(9'h1C3, 3'b011, 1, 0, 0);
    for (int i = 0; i < 20; i++) begin
      adv_i = (i % 3 == 0); @(negedge clk);
    end
    adv_i = 0;
    cur_req = "R2"; kick(9'h011, 3'b011, 0, 0, 0); run(3);
    kick(9'h1A2, 3'b010, 1, 0, 0); run(5);
    cur_req = "R12"; kick(9'h044, 3'b011, 0, 0, 0); run(2);
    start_i = 1; start_col_i = 9'h0E9; len_code_i = 3'b010; ilv_i = 0;
    wr_i = 0; adv_i = 1; term_i = 1;
    @(negedge clk);
    start_i = 0; term_i = 0; run(5);
    cur_req = "R12";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      start_i = (r < 6);
      start_col_i = 9'($urandom_range(0, 511));
      len_code_i = 3'($urandom_range(0, 7));
      ilv_i = 1'($urandom_range(0, 1));
      wr_i = 1'($urandom_range(0, 1));
      wr_single_i = 1'($urandom_range(0, 1));
      adv_i = ($urandom_range(0, 3) != 0);
      term_i = ($urandom_range(0, 99) < 3);
      @(negedge clk);
    end
    idle(); idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule